// File: doc/BRIEF.md
# Sorted Hardware Sleep Timer Queue

The block keeps a set of sleeping threads and wakes each one at the exact clock tick it asked for. A sleep request carries a thread identifier and a delay in clock ticks. On acceptance the block adds the delay to a free-running 32-bit tick counter, which gives an absolute deadline. It then places the entry into a register array that is always ordered by deadline. Because the array is sorted, only the head slot is compared with the current tick, and this happens on every cycle. Sleep resolution is therefore one clock tick, with no rounding to a coarser scheduling period.

When the head deadline has been reached, the block presents the thread identifier on a wake-up port that uses a valid/ready handshake. The port connects directly to the manager of the ready queue. The block does not raise a processor interrupt. When the handshake completes, the head entry is removed and the next entry moves up to become the head. Entries that expire together leave one per cycle, in deadline order. Entries with equal deadlines leave in the order they were accepted.

A request is accepted while the queue has a free slot. Full and empty flags show how much of the queue is in use.

Top module: `sleep_timer_queue`

## Requirements
- R1: While reset is held and in the first cycle after it, `q_empty` is 1, `q_full` is 0, `wake_valid` is 0 and `req_ready` is 1.
- R2: A request accepted at a clock edge with delay d (0 <= d < 2^31) makes `wake_valid` rise, carrying its `req_tid` on `wake_tid`, exactly max(d,1) cycles after that edge, provided no earlier-due entry is still waiting. `wake_valid` is never 1 when no entry is due.
- R3: Wake-ups leave in ascending deadline order (acceptance tick plus delay), whatever the order in which the requests arrived.
- R4: Entries with equal deadlines leave in the order in which they were accepted.
- R5: While `wake_valid` is 1 and `wake_ready` is 0, `wake_valid` stays 1 and `wake_tid` stays unchanged. An entry is removed only on a cycle with both signals high.
- R6: When several entries are due and `wake_ready` stays high, one entry leaves on each consecutive cycle, so N due entries drain in N cycles.
- R7: With `DEPTH` entries held, `q_full` is 1 and `req_ready` is 0. A request offered while the queue is full is not accepted and never produces a wake-up.
- R8: A removal and an insertion on the same clock edge both take effect. The removed entry is not emitted again, and the new entry is kept and emitted when it falls due.
- R9: Every accepted request produces exactly one wake-up. `q_empty` is 1 only when no entry is held, and `q_full` and `q_empty` are never 1 together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; also the tick that is counted |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | A sleep request is offered |
| req_ready | output | 1 | The queue can accept a request this cycle |
| req_tid | input | TID_W | Identifier of the thread going to sleep |
| req_delay | input | 32 | Sleep length in ticks, relative to now |
| wake_valid | output | 1 | The head entry is due; a wake-up is offered |
| wake_ready | input | 1 | The ready-queue manager takes the wake-up |
| wake_tid | output | TID_W | Identifier of the thread to wake |
| q_full | output | 1 | All slots are occupied |
| q_empty | output | 1 | No slot is occupied |

## Verification
Damage to the sorted order shows up at the port on the first cycle the misplaced entry reaches the head: the wrong identifier appears on `wake_tid`, or it appears in the wrong cycle. The bench keeps its own deadline list and checks both the identifier and the exact cycle of every wake-up, so an error is caught in the cycle it becomes visible. A wrong occupancy count or lost slot contents show up as a full or empty flag that disagrees with the accepted and emitted totals. They also show up as a wake-up that never arrives, which the final drain check catches. Faults in handshake timing show up as a wake-up that disappears or changes while it is stalled.

// File: rtl/stq_pkg.sv
package stq_pkg;

  // Width of the free-running tick counter and of every deadline.
  localparam int unsigned TICK_W = 32;

  typedef logic [TICK_W-1:0] tick_t;

  // Deadline of a request accepted while the counter reads 'now'.
  function automatic tick_t tick_deadline(input tick_t now, input tick_t delay);
    return now + delay;
  endfunction

  // True when 'a' lies strictly later than 'b' on the wrapping time line.
  function automatic logic tick_after(input tick_t a, input tick_t b);
    tick_t diff;
    diff = a - b;
    return (!diff[TICK_W-1]) && (diff != '0);
  endfunction

  // True once 'now' has reached or passed deadline 'due'.
  function automatic logic tick_reached(input tick_t now, input tick_t due);
    tick_t diff;
    diff = now - due;
    return !diff[TICK_W-1];
  endfunction

endpackage

// File: rtl/stq_tick_counter.sv
module stq_tick_counter
  import stq_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  output tick_t now_tick
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      now_tick <= '0;
    end else begin
      now_tick <= now_tick + tick_t'(1);
    end
  end

endmodule

// File: rtl/stq_slot.sv
module stq_slot
  import stq_pkg::*;
#(
  parameter int TID_W   = 8,
  parameter bit IS_HEAD = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pop,
  input  logic             ins,
  input  tick_t            ins_key,
  input  logic [TID_W-1:0] ins_tid,
  input  logic             up_vld,
  input  tick_t            up_key,
  input  logic [TID_W-1:0] up_tid,
  input  logic             dn_vld,
  input  tick_t            dn_key,
  input  logic [TID_W-1:0] dn_tid,
  output logic             q_vld,
  output tick_t            q_key,
  output logic [TID_W-1:0] q_tid
);

  // View of this slot and of the slot below after an optional removal.
  logic             s_vld, d_vld;
  tick_t            s_key, d_key;
  logic [TID_W-1:0] s_tid, d_tid;
  logic             s_keep, d_keep;
  logic             nxt_vld;
  tick_t            nxt_key;
  logic [TID_W-1:0] nxt_tid;

  always_comb begin
    if (pop) begin
      s_vld = up_vld;
      s_key = up_key;
      s_tid = up_tid;
      d_vld = q_vld;
      d_key = q_key;
      d_tid = q_tid;
    end else begin
      s_vld = q_vld;
      s_key = q_key;
      s_tid = q_tid;
      d_vld = dn_vld;
      d_key = dn_key;
      d_tid = dn_tid;
    end
    // An entry stays ahead of the newcomer unless its deadline is later.
    s_keep = s_vld && !tick_after(s_key, ins_key);
    d_keep = IS_HEAD ? 1'b1 : (d_vld && !tick_after(d_key, ins_key));
  end

  always_comb begin
    if (!ins || s_keep) begin
      nxt_vld = s_vld;
      nxt_key = s_key;
      nxt_tid = s_tid;
    end else if (d_keep) begin
      nxt_vld = 1'b1;
      nxt_key = ins_key;
      nxt_tid = ins_tid;
    end else begin
      nxt_vld = d_vld;
      nxt_key = d_key;
      nxt_tid = d_tid;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_vld <= 1'b0;
      q_key <= '0;
      q_tid <= '0;
    end else begin
      q_vld <= nxt_vld;
      q_key <= nxt_key;
      q_tid <= nxt_tid;
    end
  end

endmodule

// File: rtl/stq_sorted_store.sv
module stq_sorted_store
  import stq_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int TID_W = 8,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ins_evt,
  input  tick_t            ins_key,
  input  logic [TID_W-1:0] ins_tid,
  input  logic             pop_evt,
  output logic             head_vld,
  output tick_t            head_key,
  output logic [TID_W-1:0] head_tid,
  output logic             second_vld,
  output tick_t            second_key,
  output logic [CNT_W-1:0] occ,
  output logic             full,
  output logic             empty
);

  // Index 0 and DEPTH+1 are empty boundary slots; slot i lives at i+1.
  logic             v_a [DEPTH+1:0];
  tick_t            k_a [DEPTH+1:0];
  logic [TID_W-1:0] t_a [DEPTH+1:0];

  assign v_a[0]       = 1'b0;
  assign k_a[0]       = '0;
  assign t_a[0]       = '0;
  assign v_a[DEPTH+1] = 1'b0;
  assign k_a[DEPTH+1] = '0;
  assign t_a[DEPTH+1] = '0;

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    stq_slot #(
      .TID_W   (TID_W),
      .IS_HEAD (i == 0)
    ) u_slot (
      .clk     (clk),
      .rst_n   (rst_n),
      .pop     (pop_evt),
      .ins     (ins_evt),
      .ins_key (ins_key),
      .ins_tid (ins_tid),
      .up_vld  (v_a[i+2]),
      .up_key  (k_a[i+2]),
      .up_tid  (t_a[i+2]),
      .dn_vld  (v_a[i]),
      .dn_key  (k_a[i]),
      .dn_tid  (t_a[i]),
      .q_vld   (v_a[i+1]),
      .q_key   (k_a[i+1]),
      .q_tid   (t_a[i+1])
    );
  end

  assign head_vld   = v_a[1];
  assign head_key   = k_a[1];
  assign head_tid   = t_a[1];
  assign second_vld = v_a[2];
  assign second_key = k_a[2];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      occ <= '0;
    end else begin
      case ({ins_evt, pop_evt})
        2'b10:   occ <= occ + CNT_W'(1);
        2'b01:   occ <= occ - CNT_W'(1);
        default: occ <= occ;
      endcase
    end
  end

  assign full  = (occ == CNT_W'(DEPTH));
  assign empty = (occ == '0);

endmodule

// File: rtl/stq_wake_port.sv
module stq_wake_port
  import stq_pkg::*;
#(
  parameter int TID_W = 8
) (
  input  tick_t            now_tick,
  input  logic             head_vld,
  input  tick_t            head_key,
  input  logic [TID_W-1:0] head_tid,
  input  logic             wake_ready,
  output logic             head_due,
  output logic             wake_valid,
  output logic [TID_W-1:0] wake_tid,
  output logic             pop_evt
);

  assign head_due   = head_vld && tick_reached(now_tick, head_key);
  assign wake_valid = head_due;
  assign wake_tid   = head_tid;
  assign pop_evt    = head_due && wake_ready;

endmodule

// File: rtl/sleep_timer_queue.sv
module sleep_timer_queue
  import stq_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int TID_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic [TID_W-1:0]    req_tid,
  input  logic [TICK_W-1:0]   req_delay,
  output logic                wake_valid,
  input  logic                wake_ready,
  output logic [TID_W-1:0]    wake_tid,
  output logic                q_full,
  output logic                q_empty
);

  localparam int CNT_W = $clog2(DEPTH + 1);

  // Internal events brought out by name for the bound checker.
  tick_t            now_tick;
  tick_t            ins_key;
  logic             ins_evt;
  logic             pop_evt;
  logic             head_due;
  logic             head_vld;
  tick_t            head_key;
  logic [TID_W-1:0] head_tid;
  logic             second_vld;
  tick_t            second_key;
  logic [CNT_W-1:0] occ;

  assign req_ready = !q_full;
  assign ins_evt   = req_valid && req_ready;
  assign ins_key   = tick_deadline(now_tick, req_delay);

  stq_tick_counter u_ticks (
    .clk      (clk),
    .rst_n    (rst_n),
    .now_tick (now_tick)
  );

  stq_sorted_store #(
    .DEPTH (DEPTH),
    .TID_W (TID_W)
  ) u_store (
    .clk        (clk),
    .rst_n      (rst_n),
    .ins_evt    (ins_evt),
    .ins_key    (ins_key),
    .ins_tid    (req_tid),
    .pop_evt    (pop_evt),
    .head_vld   (head_vld),
    .head_key   (head_key),
    .head_tid   (head_tid),
    .second_vld (second_vld),
    .second_key (second_key),
    .occ        (occ),
    .full       (q_full),
    .empty      (q_empty)
  );

  stq_wake_port #(
    .TID_W (TID_W)
  ) u_wake (
    .now_tick   (now_tick),
    .head_vld   (head_vld),
    .head_key   (head_key),
    .head_tid   (head_tid),
    .wake_ready (wake_ready),
    .head_due   (head_due),
    .wake_valid (wake_valid),
    .wake_tid   (wake_tid),
    .pop_evt    (pop_evt)
  );

endmodule

// File: rtl/stq_checks.sv
module stq_checks
  import stq_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int TID_W = 8,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_ready,
  input logic             wake_valid,
  input logic             wake_ready,
  input logic [TID_W-1:0] wake_tid,
  input logic             q_full,
  input logic             q_empty,
  input logic             ins_evt,
  input logic             pop_evt,
  input tick_t            head_key,
  input logic             second_vld,
  input tick_t            second_key,
  input logic [CNT_W-1:0] occ
);

  AST_WAKE_NEEDS_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    wake_valid |-> !q_empty); // R2

  AST_HEAD_NOT_LATER: assert property (@(posedge clk) disable iff (!rst_n)
    second_vld |-> !tick_after(head_key, second_key)); // R3

  AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (wake_valid && !wake_ready) |=> (wake_valid && $stable(wake_tid))); // R5

  AST_FULL_REFUSES: assert property (@(posedge clk) disable iff (!rst_n)
    q_full |-> (!req_ready && !ins_evt)); // R7

  AST_OCC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (occ == CNT_W'($past(occ) + CNT_W'($past(ins_evt)) - CNT_W'($past(pop_evt))))); // R8

  AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(q_full && q_empty)); // R9

endmodule

bind sleep_timer_queue stq_checks #(
  .DEPTH (DEPTH),
  .TID_W (TID_W)
) u_checks (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_ready  (req_ready),
  .wake_valid (wake_valid),
  .wake_ready (wake_ready),
  .wake_tid   (wake_tid),
  .q_full     (q_full),
  .q_empty    (q_empty),
  .ins_evt    (ins_evt),
  .pop_evt    (pop_evt),
  .head_key   (head_key),
  .second_vld (second_vld),
  .second_key (second_key),
  .occ        (occ)
);

// File: tb/sleep_timer_queue_tb.sv
`timescale 1ns/1ps
module sleep_timer_queue_tb;

  localparam int DEPTH = 16;
  localparam int TID_W = 8;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             req_valid;
  logic             req_ready;
  logic [TID_W-1:0] req_tid;
  logic [31:0]      req_delay;
  logic             wake_valid;
  logic             wake_ready;
  logic [TID_W-1:0] wake_tid;
  logic             q_full;
  logic             q_empty;

  always #2 clk = ~clk;

  sleep_timer_queue #(.DEPTH(DEPTH), .TID_W(TID_W)) u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .req_tid    (req_tid),
    .req_delay  (req_delay),
    .wake_valid (wake_valid),
    .wake_ready (wake_ready),
    .wake_tid   (wake_tid),
    .q_full     (q_full),
    .q_empty    (q_empty)
  );

  typedef struct {
    int        tid;
    bit [31:0] acc;
    bit [31:0] due;
    int        seq;
  } ent_t;

  ent_t      sb[$];
  int        got[$];
  int        n_chk = 0;
  int        n_fail = 0;
  int        seq_ctr = 0;
  int        n_acc = 0;
  int        n_wake = 0;
  bit [31:0] tb_now;

  // Bench time reference: ticks elapsed since reset release.
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) tb_now <= 0;
    else        tb_now <= tb_now + 1;
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d (t=%0t)", req, act, exp, $time);
    end
  endtask

  // Monitor: picks the earliest-due stored entry (ties by acceptance order).
  always @(negedge clk) begin
    int bi;
    bit ev;
    if (rst_n === 1'b1) begin
      bi = -1;
      foreach (sb[i]) begin
        if (sb[i].acc < tb_now) begin
          if (bi < 0 || sb[i].due < sb[bi].due ||
              (sb[i].due == sb[bi].due && sb[i].seq < sb[bi].seq)) bi = i;
        end
      end
      ev = (bi >= 0) && (sb[bi].due <= tb_now);
      chk(wake_valid === ev, "R2 wake timing", longint'(wake_valid), longint'(ev));
      if (ev && wake_valid === 1'b1) begin
        chk(int'(wake_tid) == sb[bi].tid, "R3/R4 wake identifier", longint'(wake_tid), longint'(sb[bi].tid));
        if (wake_ready === 1'b1) begin
          got.push_back(int'(wake_tid));
          sb.delete(bi);
          n_wake++;
        end
      end
    end
  end

  task automatic idle(input int n);
    repeat (n) begin
      @(posedge clk);
      #1;
    end
  endtask

  // Driver: offers one request for one cycle; pushes the expectation if taken.
  task automatic send(input int tid, input bit [31:0] d, output bit took);
    req_valid = 1'b1;
    req_tid   = tid[TID_W-1:0];
    req_delay = d;
    @(negedge clk);
    took = req_ready;
    if (req_ready) begin
      sb.push_back('{tid, tb_now, tb_now + d, seq_ctr});
      seq_ctr++;
      n_acc++;
    end
    @(posedge clk);
    #1;
    req_valid = 1'b0;
  endtask

  task automatic drain();
    wake_ready = 1'b1;
    for (int k = 0; k < 5000 && sb.size() != 0; k++) idle(1);
    idle(2);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    bit        took;
    bit [15:0] lf;
    rst_n      = 1'b0;
    req_valid  = 1'b0;
    req_tid    = '0;
    req_delay  = '0;
    wake_ready = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: state while reset is held
    chk(q_empty == 1'b1, "R1 empty in reset", q_empty, 1);
    chk(q_full == 1'b0, "R1 full in reset", q_full, 0);
    chk(wake_valid == 1'b0, "R1 wake in reset", wake_valid, 0);
    chk(req_ready == 1'b1, "R1 ready in reset", req_ready, 1);
    @(posedge clk);
    #1;
    rst_n = 1'b1;
    @(negedge clk);
    chk(q_empty == 1'b1 && wake_valid == 1'b0, "R1 after release", wake_valid, 0);
    @(posedge clk);
    #1;

    // R2: exact latency for delay 7 and delay 0
    wake_ready = 1'b1;
    send(5, 7, took);
    for (int k = 1; k <= 7; k++) begin
      @(negedge clk);
      if (k < 7) chk(wake_valid == 1'b0, "R2 not yet due", wake_valid, 0);
      else       chk(wake_valid == 1'b1 && wake_tid == 5, "R2 due after 7", wake_tid, 5);
    end
    @(posedge clk);
    #1;
    send(6, 0, took);
    @(negedge clk);
    chk(wake_valid == 1'b1 && wake_tid == 6, "R2 zero delay next cycle", wake_tid, 6);
    @(posedge clk);
    #1;
    drain();
    chk(q_empty == 1'b1, "R9 empty after drain", q_empty, 1);

    // R3: out-of-order arrival, sorted departure
    got.delete();
    send(1, 30, took);
    send(2, 10, took);
    send(3, 20, took);
    drain();
    chk(got.size() == 3 && got[0] == 2 && got[1] == 3 && got[2] == 1,
        "R3 deadline order", got.size(), 3);

    // R4: equal deadlines leave in acceptance order
    got.delete();
    send(10, 12, took);
    send(11, 11, took);
    send(12, 10, took);
    drain();
    chk(got.size() == 3 && got[0] == 10 && got[1] == 11 && got[2] == 12,
        "R4 tie order", got.size(), 3);

    // R5 stall, then R6 back-to-back drain
    got.delete();
    wake_ready = 1'b0;
    for (int i = 0; i < 4; i++) send(21 + i, 2, took);
    idle(15);
    @(negedge clk);
    chk(wake_valid == 1'b1 && wake_tid == 21, "R5 held while stalled", wake_tid, 21);
    chk(q_empty == 1'b0, "R5 nothing removed", q_empty, 0);
    @(posedge clk);
    #1;
    wake_ready = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk(q_empty == 1'b1, "R6 four due drain in four cycles", q_empty, 1);
    chk(got.size() == 4, "R6 wake count", got.size(), 4);
    @(posedge clk);
    #1;

    // R7: fill, refuse, drain
    got.delete();
    wake_ready = 1'b0;
    for (int i = 0; i < DEPTH; i++) begin
      send(40 + i, 300, took);
      chk(took == 1'b1, "R7 accepted below depth", took, 1);
    end
    @(negedge clk);
    chk(q_full == 1'b1 && req_ready == 1'b0, "R7 full flag and ready", q_full, 1);
    @(posedge clk);
    #1;
    send(99, 1, took);
    chk(took == 1'b0, "R7 refused while full", took, 0);
    send(99, 1, took);
    chk(took == 1'b0, "R7 refused again", took, 0);
    drain();
    chk(got.size() == DEPTH, "R7 no extra wake", got.size(), DEPTH);

    // R8: removal and insertion on one edge
    got.delete();
    wake_ready = 1'b0;
    send(50, 2, took);
    idle(4);
    wake_ready = 1'b1;
    send(51, 5, took);
    @(negedge clk);
    chk(q_empty == 1'b0 && wake_valid == 1'b0, "R8 new entry kept, old gone", q_empty, 0);
    @(posedge clk);
    #1;
    drain();
    chk(got.size() == 2 && got[0] == 50 && got[1] == 51, "R8 both effective", got.size(), 2);

    // Mixed traffic with irregular back-pressure
    lf = 16'hACE1;
    for (int n = 0; n < 400; n++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      wake_ready = lf[0] | lf[3];
      if (lf[5]) send(int'(lf[15:8]), bit'(32'(lf[12:7] % 40)), took);
      else       idle(1);
    end
    drain();
    chk(q_empty == 1'b1 && sb.size() == 0, "R9 empty at end", sb.size(), 0);
    chk(n_wake == n_acc, "R9 one wake per request", n_wake, n_acc);
    finish_run();
  end

endmodule